// File: doc/BRIEF.md
# Translation Fault Exception Entry Sequencer

This block sits beside the address-translation unit of a processor core. The translation unit can report a write to a page that has never been written, even though a valid entry with suitable rights matched. The block then captures the faulting virtual address, the current PC, the delay-slot flag, the branch PC, the current status register and the vector base. From those values it produces the write-enables and write data for the processor's exception state registers. It also produces a redirect of instruction fetch to the handler vector.

The block serves the return-from-exception command as well. That command restores the status register from the saved status register and restores the PC from the saved PC. A small monitor counts retired instructions after each translation-buffer load command. It flags a return that comes too soon after such a load.

The control is a four-state machine:
- `ST_IDLE` waits for work.
- `ST_COMMIT` drives every register write of one fault in a single cycle.
- `ST_REDIRECT` drives the fetch redirect.
- `ST_RETURN` drives the restore.

The transitions are:
- accept: `ST_IDLE` to `ST_COMMIT`.
- advance: `ST_COMMIT` to `ST_REDIRECT`.
- finish: `ST_REDIRECT` to `ST_IDLE`.
- take-return: `ST_IDLE` to `ST_RETURN`.
- restore-done: `ST_RETURN` to `ST_IDLE`.

Top module: `xcpt_entry_seq`

## Requirements
- R1: After reset, every write-enable, `fetch_we`, `nest_err` and `order_err` is 0.
- R2: A fault is accepted when `flt_valid` is 1 in idle and bit 28 (block bit) of `sr_cur` is 0. In the next cycle `th_we`, `fa_we`, `ec_we`, `spc_we`, `ssr_we` and `sr_we` are all 1 for exactly one cycle, and `fetch_we` is 0 in that cycle.
- R3: In the commit cycle `th_vpn` equals bits 31..10 of the faulting address, and `fa_data` equals the full faulting address.
- R4: In the commit cycle `ec_data` is 12'h080.
- R5: In the commit cycle `spc_data` is `cur_pc` when `in_dslot` was 0, and `br_pc` when it was 1.
- R6: In the commit cycle `ssr_data` equals `sr_cur` as sampled with the fault. `sr_data` equals that same value with bits 30 (privilege), 29 (bank) and 28 (block) forced to 1.
- R7: In the cycle after the commit cycle `fetch_we` is 1, with `fetch_pc` equal to `vbr_cur` (sampled with the fault) plus 32'h100. No register write-enable is set in that cycle.
- R8: A fault report that is not accepted sets `nest_err` for one cycle in the next cycle and starts no register write. This covers a fault with the block bit set, and a fault while the sequencer is busy.
- R9: A return command taken in idle sets `sr_we` and `fetch_we` together in the next cycle, for one cycle. `sr_data` equals `ssr_cur` and `fetch_pc` equals `spc_cur`, and no other write-enable is set.
- R10: `order_err` is 1 in the restore cycle when fewer than 2 `insn_retire` pulses came after the latest `tlb_load` pulse. It is 0 when 2 or more came, or when no load has occurred since reset.
- R11: When `flt_valid` and `rte_req` are both 1 in the same idle cycle, the fault is handled and the return command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | Clean-page write fault report |
| flt_vaddr | input | 32 | Faulting virtual address |
| cur_pc | input | 32 | PC of the faulting instruction |
| in_dslot | input | 1 | Fault occurred in a delay slot |
| br_pc | input | 32 | PC of the related delayed branch |
| sr_cur | input | 32 | Current status register |
| ssr_cur | input | 32 | Current saved status register |
| spc_cur | input | 32 | Current saved PC |
| vbr_cur | input | 32 | Current vector base register |
| rte_req | input | 1 | Return-from-exception command |
| tlb_load | input | 1 | Translation-buffer load command issued |
| insn_retire | input | 1 | One instruction retired |
| th_we | output | 1 | Translation-high page field write enable |
| th_vpn | output | 22 | Virtual page number to write |
| fa_we | output | 1 | Fault-address register write enable |
| fa_data | output | 32 | Fault-address write data |
| ec_we | output | 1 | Exception-code register write enable |
| ec_data | output | 12 | Exception code |
| spc_we | output | 1 | Saved PC write enable |
| spc_data | output | 32 | Saved PC write data |
| ssr_we | output | 1 | Saved status register write enable |
| ssr_data | output | 32 | Saved status write data |
| sr_we | output | 1 | Status register write enable |
| sr_data | output | 32 | Status register write data |
| fetch_we | output | 1 | Fetch redirect strobe |
| fetch_pc | output | 32 | New fetch address |
| nest_err | output | 1 | Fault report refused |
| order_err | output | 1 | Return came too soon after a load |

## Verification
The assertions assume that the fault inputs and the status value are stable for the whole cycle in which `flt_valid` is sampled. They also assume that `tlb_load` and `insn_retire` are single-cycle pulses that describe the instruction stream. The stimulus drives every input at the falling edge and holds each request for exactly one cycle. It lowers the block bit in `sr_cur` before each fault that it expects to be accepted, and it raises the bit only for the refusal cases.

// File: rtl/xcpt_pkg.sv
package xcpt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_COMMIT   = 2'd1,
        ST_REDIRECT = 2'd2,
        ST_RETURN   = 2'd3
    } seq_state_e;

    localparam int DEF_AW      = 32;
    localparam int DEF_SW      = 32;
    localparam int DEF_ECW     = 12;
    localparam int DEF_VPN_LSB = 10;
    localparam int DEF_MD_BIT  = 30;
    localparam int DEF_RB_BIT  = 29;
    localparam int DEF_BL_BIT  = 28;
    localparam int DEF_MIN_GAP = 2;
endpackage

// File: rtl/xcpt_fsm.sv
module xcpt_fsm
    import xcpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flt_valid,
    input  logic       bl_set,
    input  logic       rte_req,
    output seq_state_e state,
    output logic       accept,
    output logic       take_rte,
    output logic       nest_q
);
    seq_state_e nxt;

    always_comb begin
        accept   = (state == ST_IDLE) && flt_valid && !bl_set;
        take_rte = (state == ST_IDLE) && rte_req && !flt_valid;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept)        nxt = ST_COMMIT;
                else if (take_rte) nxt = ST_RETURN;
            end
            ST_COMMIT:   nxt = ST_REDIRECT;
            ST_REDIRECT: nxt = ST_IDLE;
            ST_RETURN:   nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            nest_q <= 1'b0;
        end else begin
            state  <= nxt;
            nest_q <= flt_valid && !accept;
        end
    end

    // R2
    accept_to_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> state == ST_COMMIT);
    // R7
    commit_to_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_COMMIT |=> state == ST_REDIRECT);
    // R11
    fault_over_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && flt_valid && rte_req) |=> state != ST_RETURN);
endmodule

// File: rtl/xcpt_capture.sv
module xcpt_capture #(
    parameter int AW = 32,
    parameter int SW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          take_rte,
    input  logic [AW-1:0] flt_vaddr,
    input  logic [AW-1:0] cur_pc,
    input  logic          in_dslot,
    input  logic [AW-1:0] br_pc,
    input  logic [SW-1:0] sr_cur,
    input  logic [AW-1:0] vbr_cur,
    input  logic [SW-1:0] ssr_cur,
    input  logic [AW-1:0] spc_cur,
    output logic [AW-1:0] cap_addr,
    output logic [AW-1:0] cap_spc,
    output logic [SW-1:0] cap_sr,
    output logic [AW-1:0] cap_vbr,
    output logic [SW-1:0] ret_sr,
    output logic [AW-1:0] ret_pc
);
    logic [AW-1:0] pc_pick;

    always_comb pc_pick = in_dslot ? br_pc : cur_pc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_spc  <= '0;
            cap_sr   <= '0;
            cap_vbr  <= '0;
            ret_sr   <= '0;
            ret_pc   <= '0;
        end else begin
            if (accept) begin
                cap_addr <= flt_vaddr;
                cap_spc  <= pc_pick;
                cap_sr   <= sr_cur;
                cap_vbr  <= vbr_cur;
            end
            if (take_rte) begin
                ret_sr <= ssr_cur;
                ret_pc <= spc_cur;
            end
        end
    end

    // R5
    spc_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_dslot) |=> cap_spc == $past(br_pc));
endmodule

// File: rtl/xcpt_order_mon.sv
module xcpt_order_mon #(
    parameter int MIN_GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tlb_load,
    input  logic insn_retire,
    input  logic take_rte,
    output logic order_err
);
    localparam int CW = $clog2(MIN_GAP + 1);
    localparam logic [CW-1:0] GAP_C = CW'(MIN_GAP);

    logic [CW-1:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt   <= GAP_C;
            order_err <= 1'b0;
        end else begin
            if (tlb_load)
                gap_cnt <= '0;
            else if (insn_retire && gap_cnt < GAP_C)
                gap_cnt <= gap_cnt + 1'b1;
            order_err <= take_rte && (gap_cnt < GAP_C);
        end
    end

    // R10
    order_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        order_err |-> $past(take_rte));
    // R10
    order_err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_rte && gap_cnt == GAP_C) |=> !order_err);
endmodule

// File: rtl/xcpt_entry_seq.sv
module xcpt_entry_seq
    import xcpt_pkg::*;
#(
    parameter int          AW      = DEF_AW,
    parameter int          SW      = DEF_SW,
    parameter int          ECW     = DEF_ECW,
    parameter int          VPN_LSB = DEF_VPN_LSB,
    parameter int          MD_BIT  = DEF_MD_BIT,
    parameter int          RB_BIT  = DEF_RB_BIT,
    parameter int          BL_BIT  = DEF_BL_BIT,
    parameter int          MIN_GAP = DEF_MIN_GAP,
    parameter logic [11:0] EC_CODE = 12'h080,
    parameter logic [31:0] VEC_OFF = 32'h0000_0100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flt_valid,
    input  logic [AW-1:0]       flt_vaddr,
    input  logic [AW-1:0]       cur_pc,
    input  logic                in_dslot,
    input  logic [AW-1:0]       br_pc,
    input  logic [SW-1:0]       sr_cur,
    input  logic [SW-1:0]       ssr_cur,
    input  logic [AW-1:0]       spc_cur,
    input  logic [AW-1:0]       vbr_cur,
    input  logic                rte_req,
    input  logic                tlb_load,
    input  logic                insn_retire,
    output logic                th_we,
    output logic [AW-VPN_LSB-1:0] th_vpn,
    output logic                fa_we,
    output logic [AW-1:0]       fa_data,
    output logic                ec_we,
    output logic [ECW-1:0]      ec_data,
    output logic                spc_we,
    output logic [AW-1:0]       spc_data,
    output logic                ssr_we,
    output logic [SW-1:0]       ssr_data,
    output logic                sr_we,
    output logic [SW-1:0]       sr_data,
    output logic                fetch_we,
    output logic [AW-1:0]       fetch_pc,
    output logic                nest_err,
    output logic                order_err
);
    localparam logic [SW-1:0] FORCE_MASK =
        (SW'(1) << MD_BIT) | (SW'(1) << RB_BIT) | (SW'(1) << BL_BIT);
    localparam logic [AW-1:0] VEC_C = AW'(VEC_OFF);

    seq_state_e    state;
    logic          accept, take_rte, nest_q;
    logic [AW-1:0] cap_addr, cap_spc, cap_vbr, ret_pc;
    logic [SW-1:0] cap_sr, ret_sr;

    xcpt_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .flt_valid(flt_valid),
        .bl_set   (sr_cur[BL_BIT]),
        .rte_req  (rte_req),
        .state    (state),
        .accept   (accept),
        .take_rte (take_rte),
        .nest_q   (nest_q)
    );

    xcpt_capture #(.AW(AW), .SW(SW)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .take_rte (take_rte),
        .flt_vaddr(flt_vaddr),
        .cur_pc   (cur_pc),
        .in_dslot (in_dslot),
        .br_pc    (br_pc),
        .sr_cur   (sr_cur),
        .vbr_cur  (vbr_cur),
        .ssr_cur  (ssr_cur),
        .spc_cur  (spc_cur),
        .cap_addr (cap_addr),
        .cap_spc  (cap_spc),
        .cap_sr   (cap_sr),
        .cap_vbr  (cap_vbr),
        .ret_sr   (ret_sr),
        .ret_pc   (ret_pc)
    );

    xcpt_order_mon #(.MIN_GAP(MIN_GAP)) u_ord (
        .clk        (clk),
        .rst_n      (rst_n),
        .tlb_load   (tlb_load),
        .insn_retire(insn_retire),
        .take_rte   (take_rte),
        .order_err  (order_err)
    );

    always_comb begin
        th_we    = 1'b0;
        th_vpn   = '0;
        fa_we    = 1'b0;
        fa_data  = '0;
        ec_we    = 1'b0;
        ec_data  = '0;
        spc_we   = 1'b0;
        spc_data = '0;
        ssr_we   = 1'b0;
        ssr_data = '0;
        sr_we    = 1'b0;
        sr_data  = '0;
        fetch_we = 1'b0;
        fetch_pc = '0;
        nest_err = nest_q;
        unique case (state)
            ST_IDLE: ;
            ST_COMMIT: begin
                th_we    = 1'b1;
                th_vpn   = cap_addr[AW-1:VPN_LSB];
                fa_we    = 1'b1;
                fa_data  = cap_addr;
                ec_we    = 1'b1;
                ec_data  = ECW'(EC_CODE);
                spc_we   = 1'b1;
                spc_data = cap_spc;
                ssr_we   = 1'b1;
                ssr_data = cap_sr;
                sr_we    = 1'b1;
                sr_data  = cap_sr | FORCE_MASK;
            end
            ST_REDIRECT: begin
                fetch_we = 1'b1;
                fetch_pc = cap_vbr + VEC_C;
            end
            ST_RETURN: begin
                sr_we    = 1'b1;
                sr_data  = ret_sr;
                fetch_we = 1'b1;
                fetch_pc = ret_pc;
            end
            default: ;
        endcase
    end

    // R2
    commit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ec_we |=> !ec_we && !fa_we && !th_we);
    // R3
    fa_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && state == ST_IDLE && !sr_cur[BL_BIT]) |=> fa_data == $past(flt_vaddr));
    // R6
    ssr_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && state == ST_IDLE && !sr_cur[BL_BIT]) |=> ssr_data == $past(sr_cur));
    // R7
    redirect_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ec_we |=> fetch_we && !sr_we);
    // R8
    nest_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && sr_cur[BL_BIT] && state == ST_IDLE) |=> nest_err && !ec_we);
    // R9
    restore_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rte_req && !flt_valid && state == ST_IDLE) |=> sr_we && fetch_we && !ssr_we);
endmodule

// File: tb/xcpt_entry_seq_tb.sv
`timescale 1ns/1ps
module xcpt_entry_seq_tb_top;
    localparam logic [31:0] FMASK = 32'h7000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        flt_valid = 0, in_dslot = 0, rte_req = 0, tlb_load = 0, insn_retire = 0;
    logic [31:0] flt_vaddr = 0, cur_pc = 0, br_pc = 0, sr_cur = 0, ssr_cur = 0, spc_cur = 0, vbr_cur = 0;
    logic        th_we, fa_we, ec_we, spc_we, ssr_we, sr_we, fetch_we, nest_err, order_err;
    logic [21:0] th_vpn;
    logic [11:0] ec_data;
    logic [31:0] fa_data, spc_data, ssr_data, sr_data, fetch_pc;

    xcpt_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_vaddr(flt_vaddr),
        .cur_pc(cur_pc), .in_dslot(in_dslot), .br_pc(br_pc), .sr_cur(sr_cur),
        .ssr_cur(ssr_cur), .spc_cur(spc_cur), .vbr_cur(vbr_cur), .rte_req(rte_req),
        .tlb_load(tlb_load), .insn_retire(insn_retire), .th_we(th_we), .th_vpn(th_vpn),
        .fa_we(fa_we), .fa_data(fa_data), .ec_we(ec_we), .ec_data(ec_data),
        .spc_we(spc_we), .spc_data(spc_data), .ssr_we(ssr_we), .ssr_data(ssr_data),
        .sr_we(sr_we), .sr_data(sr_data), .fetch_we(fetch_we), .fetch_pc(fetch_pc),
        .nest_err(nest_err), .order_err(order_err)
    );

    typedef struct {
        string       tag;
        logic [8:0]  we;
        logic [21:0] vpn;
        logic [31:0] fa, spc, ssr, sr, fpc;
        logic [11:0] ec;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;

    function automatic exp_t blank(string tag);
        exp_t e;
        e.tag = tag; e.we = '0; e.vpn = '0; e.fa = '0; e.spc = '0;
        e.ssr = '0; e.sr = '0; e.fpc = '0; e.ec = '0;
        return e;
    endfunction

    // we bit order: th fa ec spc ssr sr fetch nest order
    function automatic exp_t sample();
        exp_t a;
        a = blank("act");
        a.we = {th_we, fa_we, ec_we, spc_we, ssr_we, sr_we, fetch_we, nest_err, order_err};
        a.vpn = th_vpn; a.fa = fa_data; a.ec = ec_data; a.spc = spc_data;
        a.ssr = ssr_data; a.sr = sr_data; a.fpc = fetch_pc;
        return a;
    endfunction

    function automatic bit match(exp_t a, exp_t e);
        if (a.we !== e.we) return 0;
        if (e.we[8] && a.vpn !== e.vpn) return 0;
        if (e.we[7] && a.fa !== e.fa) return 0;
        if (e.we[6] && a.ec !== e.ec) return 0;
        if (e.we[5] && a.spc !== e.spc) return 0;
        if (e.we[4] && a.ssr !== e.ssr) return 0;
        if (e.we[3] && a.sr !== e.sr) return 0;
        if (e.we[2] && a.fpc !== e.fpc) return 0;
        return 1;
    endfunction

    bit run_mon = 0;
    always @(negedge clk) begin
        if (run_mon && (sample().we != '0)) begin
            exp_t a, e;
            a = sample();
            total++;
            if (q.size() == 0) begin
                bad++;
                $display("FAIL unexpected activity we=%b expected none (R8/R11)", a.we);
            end else begin
                e = q.pop_front();
                if (!match(a, e)) begin
                    bad++;
                    $display("FAIL %s: actual we=%b vpn=%h fa=%h ec=%h spc=%h ssr=%h sr=%h fpc=%h expected we=%b vpn=%h fa=%h ec=%h spc=%h ssr=%h sr=%h fpc=%h",
                        e.tag, a.we, a.vpn, a.fa, a.ec, a.spc, a.ssr, a.sr, a.fpc,
                        e.we, e.vpn, e.fa, e.ec, e.spc, e.ssr, e.sr, e.fpc);
                end
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_fault(string tag, logic [31:0] va, logic [31:0] pc, logic ds,
                              logic [31:0] bpc, logic [31:0] sr, logic [31:0] vbr, logic nest_in_redirect);
        exp_t c, r;
        c = blank({tag, " R2 R3 R4 R5 R6 commit"});
        c.we = 9'b111111000;
        c.vpn = va[31:10]; c.fa = va; c.ec = 12'h080;
        c.spc = ds ? bpc : pc; c.ssr = sr; c.sr = sr | FMASK;
        r = blank({tag, " R7 redirect"});
        r.we = {7'b0000001, nest_in_redirect, 1'b0};
        r.fpc = vbr + 32'h100;
        q.push_back(c);
        q.push_back(r);
    endtask

    task automatic drive_fault(logic [31:0] va, logic [31:0] pc, logic ds,
                               logic [31:0] bpc, logic [31:0] sr, logic [31:0] vbr);
        flt_valid = 1; flt_vaddr = va; cur_pc = pc; in_dslot = ds; br_pc = bpc;
        sr_cur = sr; vbr_cur = vbr;
    endtask

    task automatic fault(string tag, logic [31:0] va, logic [31:0] pc, logic ds,
                         logic [31:0] bpc, logic [31:0] sr, logic [31:0] vbr);
        push_fault(tag, va, pc, ds, bpc, sr, vbr, 1'b0);
        drive_fault(va, pc, ds, bpc, sr, vbr);
        @(negedge clk);
        flt_valid = 0;
        idle(4);
    endtask

    task automatic rte(string tag, logic [31:0] ssr, logic [31:0] spc, logic oerr);
        exp_t e;
        e = blank({tag, " R9 R10 restore"});
        e.we = {6'b000001, 1'b1, 1'b0, oerr};
        e.sr = ssr; e.fpc = spc;
        q.push_back(e);
        rte_req = 1; ssr_cur = ssr; spc_cur = spc;
        @(negedge clk);
        rte_req = 0;
        idle(4);
    endtask

    task automatic pulse_load();
        tlb_load = 1; @(negedge clk); tlb_load = 0;
    endtask

    task automatic retire(int n);
        for (int i = 0; i < n; i++) begin
            insn_retire = 1; @(negedge clk); insn_retire = 0; @(negedge clk);
        end
    endtask

    initial begin
        for (int w = 0; w < 20000; w++) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        exp_t e;
        idle(3);
        @(negedge clk) rst_n = 1;
        @(negedge clk);
        total++;
        if (sample().we !== '0) begin
            bad++;
            $display("FAIL R1 reset: actual we=%b expected %b", sample().we, 9'b0);
        end
        run_mon = 1;

        fault("plain", 32'h1234_5678, 32'h8000_1000, 0, 32'h8000_0ffc, 32'h0000_00f0, 32'h8c00_0000);
        fault("dslot", 32'hfedc_ba98, 32'h8000_2002, 1, 32'h8000_1ffe, 32'h4000_0001, 32'h0000_0000);
        fault("bits",  32'h0000_03ff, 32'h0000_0000, 0, 32'hffff_fffe, 32'h8fff_ffff, 32'hffff_ff00);
        fault("rbset", 32'hffff_fc00, 32'h1111_2222, 1, 32'h3333_4444, 32'h2000_0000, 32'h0001_0000);

        // R8: block bit set, fault refused
        e = blank("R8 blocked fault"); e.we = 9'b000000010; q.push_back(e);
        drive_fault(32'hdead_beef, 32'h1, 0, 32'h2, 32'h1000_0000, 32'h0);
        @(negedge clk); flt_valid = 0; idle(4);

        // R8: second fault while busy (state commit) -> nest in redirect cycle
        push_fault("busy", 32'h0bad_c0de, 32'h0000_4000, 0, 32'h0, 32'h0, 32'h0200_0000, 1'b1);
        drive_fault(32'h0bad_c0de, 32'h0000_4000, 0, 32'h0, 32'h0, 32'h0200_0000);
        @(negedge clk);
        drive_fault(32'h5555_5555, 32'h6, 0, 32'h7, 32'h0, 32'h0);
        @(negedge clk); flt_valid = 0; idle(4);

        // R10: no load since reset
        rte("noload", 32'h0000_00f0, 32'h8000_1002, 0);
        // R10: one retire after load -> too soon
        pulse_load(); retire(1);
        rte("early", 32'h4000_0001, 32'h8000_3000, 1);
        // R10: two retires -> fine
        pulse_load(); retire(2);
        rte("spaced", 32'h7000_0003, 32'h8000_4000, 0);
        // R10: load with no retire at all
        pulse_load();
        rte("zero", 32'h0000_0000, 32'h0000_0010, 1);

        // R11: fault and return together, fault wins
        push_fault("R11 both", 32'h2468_ace0, 32'h9000_0000, 0, 32'h0, 32'h0000_0002, 32'h4000_0000, 1'b0);
        rte_req = 1; ssr_cur = 32'h1; spc_cur = 32'h2;
        drive_fault(32'h2468_ace0, 32'h9000_0000, 0, 32'h0, 32'h0000_0002, 32'h4000_0000);
        @(negedge clk); flt_valid = 0; rte_req = 0;
        idle(6);

        total++;
        if (q.size() != 0) begin
            bad++;
            $display("FAIL R2 pending items: actual %0d expected 0", q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule